// File: doc/BRIEF.md
# Multiplexed LCD Row Scanner

This block keeps the pixel memory of a 128-column dot-matrix LCD and walks through it one backplane row at a time. A host loads the memory with byte writes whenever it likes. Each pulse of a row-advance enable, which is derived from a 2.048 kHz backplane clock, moves the scan to the next row. The block then registers a 128-bit segment pattern for that row and presents it with the row index. It also raises a one-cycle frame-start strobe on row 0 and keeps a frame polarity bit that flips once per frame. An analog stage uses that bit to drive the panel with AC.

Two scan lengths are available: 32 rows per frame (64 Hz frame) or 41 rows per frame (about 50 Hz). Rows 0 to 39 come from column-oriented bytes, where each byte covers eight rows of one column. The 41st row (index 40) instead comes from a 16-byte region stored in row order. The mode input is sampled only when a frame begins.

The scan is held by a three-state machine. ST_IDLE is the state after reset, before any row has been shown. ST_VROW shows a row taken from the column-oriented pages. ST_HROW shows the extra row of 41-row mode. Every transition happens on a row-advance enable:
- IDLE to VROW is the first frame start.
- VROW to VROW is either a step to the next row or, at the end of a 32-row frame, a wrap to a new frame.
- VROW to HROW goes from row 39 to row 40 in 41-row mode.
- HROW to VROW is a wrap to a new frame.

Top module: `lcd_row_scanner`

## Requirements
- R1: After reset, row_idx is 0, seg_data is all zero, frame_start is 0 and frame_pol is 0. These hold until the first bp_tick.
- R2: Row, segment, strobe and polarity outputs change only at a clock edge where bp_tick is 1. Their new values are visible in the cycle after that edge. frame_start is the only exception: it drops back to 0 one cycle later.
- R3: With mode_41 = 0 latched, rows run 0, 1, …, 31 and then wrap to 0.
- R4: With mode_41 = 1 latched, rows run 0, 1, …, 40 and then wrap to 0.
- R5: For a row r below 40, seg_data bit c equals bit (r mod 8) of the byte at address (r div 8)·128 + c.
- R6: For row 40, seg_data bit c equals bit (c mod 8) of the byte at address 0x280 + (c div 8).
- R7: Each frame start shows row_idx = 0 together with frame_start = 1 for exactly one cycle. This includes the first bp_tick after reset.
- R8: frame_pol inverts at every frame start, so the first frame has frame_pol = 1.
- R9: mode_41 is sampled only at a frame start. A change in the middle of a frame does not alter that frame's length.
- R10: A write to any address at or above 0x290 changes no stored byte.
- R11: Writes may arrive in any cycle. The row pattern is captured at the advancing edge from the memory contents before any write on that same edge. Later writes leave seg_data unchanged until the next bp_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_tick | input | 1 | Row-advance enable, one cycle per backplane clock tick |
| mode_41 | input | 1 | 1 selects 41-row frames, 0 selects 32-row frames |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 10 | Host byte address |
| wr_data | input | 8 | Host byte data |
| seg_data | output | 128 | Segment pattern of the active row, bit c = column c |
| row_idx | output | 6 | Active backplane row |
| frame_start | output | 1 | One-cycle strobe at row 0 |
| frame_pol | output | 1 | Frame polarity, flips every frame |

## Verification
Two situations are hardest to reach from the ports.

The first is a mode change that must not take effect until the frame ends. The stimulus flips mode_41 partway through a 32-row frame and again partway through a 41-row frame. The per-cycle model then expects the old wrap point and, after it, the new one.

The second is a host write that lands on the same edge as the row advance reading that byte. This needs bp_tick held high on every cycle while pseudo-random writes hit the page currently being scanned. The model captures its pattern before applying the write, so seg_data is compared against the memory contents from before that edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int COLS       = 128;
    localparam int ROWS_SHORT = 32;
    localparam int ROWS_LONG  = 41;
    localparam int ROW_W      = $clog2(ROWS_LONG);
    localparam int PAGES      = (ROWS_LONG - 1 + 7) / 8;
    localparam int H_BASE     = PAGES * COLS;
    localparam int DEPTH      = H_BASE + COLS / 8;
    localparam int ADDR_W     = $clog2(DEPTH);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VROW = 2'd1,
        ST_HROW = 2'd2
    } scan_state_e;
endpackage

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem
    import lcd_scan_pkg::*;
#(
    parameter int N_COLS  = COLS,
    parameter int N_DEPTH = DEPTH,
    parameter int AW      = ADDR_W,
    parameter int RW      = ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [RW-1:0]     rd_row,
    input  logic              rd_is_h,
    output logic [N_COLS-1:0] rd_pattern
);
    localparam int HB   = N_DEPTH - N_COLS / 8;
    localparam int PG_W = RW - 3;

    logic [7:0]        mem_q [0:N_DEPTH-1];
    logic [N_COLS-1:0] pat_v;
    logic [N_COLS-1:0] pat_h;
    logic [PG_W-1:0]   rd_page;
    logic [2:0]        rd_bit;
    logic              wr_ok;

    assign wr_ok   = wr_en && (int'(wr_addr) < N_DEPTH);
    assign rd_page = rd_row[RW-1:3];
    assign rd_bit  = rd_row[2:0];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        logic [AW-1:0] v_addr;
        assign v_addr   = AW'(int'(rd_page) * N_COLS + c);
        assign pat_v[c] = mem_q[v_addr][rd_bit];
        assign pat_h[c] = mem_q[HB + c / 8][c % 8];
    end

    assign rd_pattern = rd_is_h ? pat_h : pat_v;

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R11
endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer
    import lcd_scan_pkg::*;
#(
    parameter int N_SHORT = ROWS_SHORT,
    parameter int N_LONG  = ROWS_LONG,
    parameter int RW      = ROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bp_tick,
    input  logic          mode_41,
    output logic [RW-1:0] nxt_row,
    output logic          nxt_is_h,
    output logic [RW-1:0] row_idx,
    output logic          frame_start,
    output logic          frame_pol
);
    localparam logic [RW-1:0] LAST_SHORT = RW'(N_SHORT - 1);
    localparam logic [RW-1:0] LAST_VLONG = RW'(N_LONG - 2);
    localparam logic [RW-1:0] H_ROW      = RW'(N_LONG - 1);

    scan_state_e   state_q, nxt_state;
    logic [RW-1:0] row_q;
    logic          mode_q, nxt_mode;
    logic          new_frame;
    logic [RW-1:0] last_v;
    logic          fs_q, pol_q;

    assign last_v = mode_q ? LAST_VLONG : LAST_SHORT;

    always_comb begin
        nxt_state = state_q;
        nxt_row   = row_q;
        nxt_mode  = mode_q;
        new_frame = 1'b0;
        if (bp_tick) begin
            unique case (state_q)
                ST_IDLE: new_frame = 1'b1;
                ST_VROW: begin
                    if (row_q == last_v) begin
                        if (mode_q) begin
                            nxt_state = ST_HROW;
                            nxt_row   = H_ROW;
                        end else begin
                            new_frame = 1'b1;
                        end
                    end else begin
                        nxt_row = row_q + 1'b1;
                    end
                end
                ST_HROW: new_frame = 1'b1;
                default: nxt_state = ST_IDLE;
            endcase
            if (new_frame) begin
                nxt_state = ST_VROW;
                nxt_row   = '0;
                nxt_mode  = mode_41;
            end
        end
    end

    assign nxt_is_h = (nxt_state == ST_HROW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= nxt_state;
            row_q   <= nxt_row;
            mode_q  <= nxt_mode;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            pol_q <= 1'b0;
        end else begin
            fs_q <= new_frame;
            if (new_frame) begin
                pol_q <= ~pol_q;
            end
        end
    end

    assign row_idx     = row_q;
    assign frame_start = fs_q;
    assign frame_pol   = pol_q;

    AST_FS_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q |-> row_q == '0); // R7
    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q |=> !fs_q); // R7
    AST_POL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q |-> pol_q != $past(pol_q)); // R8
    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= (mode_q ? H_ROW : LAST_SHORT)); // R4
    AST_HROW_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HROW |-> mode_q && row_q == H_ROW); // R6
    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> fs_q); // R9
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_tick |=> $stable(row_q) && !fs_q); // R2
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
    parameter int N_COLS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_COLS-1:0] pattern,
    output logic [N_COLS-1:0] seg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (load) begin
            seg_q <= pattern;
        end
    end

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(seg_q)); // R11
endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner
    import lcd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_tick,
    input  logic              mode_41,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [COLS-1:0]   seg_data,
    output logic [ROW_W-1:0]  row_idx,
    output logic              frame_start,
    output logic              frame_pol
);
    logic [ROW_W-1:0] nxt_row;
    logic             nxt_is_h;
    logic [COLS-1:0]  pattern;

    lcd_row_sequencer #(
        .N_SHORT (ROWS_SHORT),
        .N_LONG  (ROWS_LONG),
        .RW      (ROW_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bp_tick     (bp_tick),
        .mode_41     (mode_41),
        .nxt_row     (nxt_row),
        .nxt_is_h    (nxt_is_h),
        .row_idx     (row_idx),
        .frame_start (frame_start),
        .frame_pol   (frame_pol)
    );

    lcd_disp_mem #(
        .N_COLS  (COLS),
        .N_DEPTH (DEPTH),
        .AW      (ADDR_W),
        .RW      (ROW_W)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_row     (nxt_row),
        .rd_is_h    (nxt_is_h),
        .rd_pattern (pattern)
    );

    lcd_seg_latch #(
        .N_COLS (COLS)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bp_tick),
        .pattern (pattern),
        .seg_q   (seg_data)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_data == '0 && row_idx == '0 && !frame_pol && !bp_tick) |=> !frame_start); // R1
endmodule

// File: tb/test_lcd_row_scanner.sv
module test_lcd_row_scanner;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bp_tick = 1'b0;
    logic         mode_41 = 1'b0;
    logic         wr_en = 1'b0;
    logic [9:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic [127:0] seg_data;
    logic [5:0]   row_idx;
    logic         frame_start;
    logic         frame_pol;

    always #10 clk = ~clk;

    lcd_row_scanner i_lcd_row_scanner (
        .clk(clk), .rst_n(rst_n), .bp_tick(bp_tick), .mode_41(mode_41),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .seg_data(seg_data), .row_idx(row_idx),
        .frame_start(frame_start), .frame_pol(frame_pol)
    );

    // behavioural reference
    byte unsigned m_mem [656];
    bit           m_run;
    int           m_row;
    bit           m_mode;
    logic [127:0] m_seg;
    bit           m_fs;
    bit           m_pol;
    int           n_cmp = 0;
    int           n_bad = 0;
    string        tag = "R1";
    int unsigned  rng = 32'h1234_5678;

    function automatic int unsigned nxt_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic logic [127:0] row_bits(int r);
        logic [127:0] v;
        for (int c = 0; c < 128; c++) begin
            if (r == 40) v[c] = m_mem[640 + c / 8][c % 8];
            else         v[c] = m_mem[(r / 8) * 128 + c][r % 8];
        end
        return v;
    endfunction

    task automatic chk(string what, string req, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s %s: actual %h expected %h", tag, req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("row_idx", m_mode ? "R4" : "R3", 128'(row_idx), 128'(m_row));
        chk("seg_data", m_row == 40 ? "R6" : "R5", seg_data, m_seg);
        chk("frame_start", "R7", 128'(frame_start), 128'(m_fs));
        chk("frame_pol", "R8", 128'(frame_pol), 128'(m_pol));
    endtask

    // drive one cycle from a negedge, advance the model, compare at the next negedge
    task automatic cyc(bit tk, bit md, bit we, int a, int d);
        bp_tick = tk; mode_41 = md; wr_en = we;
        wr_addr = 10'(a); wr_data = 8'(d);
        m_fs = 1'b0;
        if (tk) begin
            if (!m_run || m_row == (m_mode ? 40 : 31)) begin
                m_run = 1'b1; m_row = 0; m_mode = md; m_fs = 1'b1; m_pol = ~m_pol;
            end else begin
                m_row++;
            end
            m_seg = row_bits(m_row);   // R11: pattern from memory before this edge's write
        end
        if (we && a < 656) m_mem[a] = 8'(d);   // R10: high addresses ignored
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_run = 0; m_row = 0; m_mode = 0; m_seg = '0; m_fs = 0; m_pol = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state holds without ticks
        tag = "R1";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);

        // load whole memory, outputs must stay idle (R2)
        tag = "R2";
        for (int a = 0; a < 656; a++) cyc(0, 0, 1, a, (a * 37 + (a >> 3)) ^ 8'h5A);

        // R10: out-of-range writes
        tag = "R10";
        for (int a = 656; a < 1024; a += 7) cyc(0, 0, 1, a, 8'hFF);
        cyc(0, 0, 1, 1023, 8'h00);

        // R3: 32-row frames, tick every third cycle; mode raised mid-frame (R9)
        tag = "R3";
        for (int t = 0; t < 50; t++) begin
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
        end
        tag = "R9";
        for (int t = 0; t < 30; t++) begin
            cyc(1, 1, 0, 0, 0);
            cyc(0, 1, 0, 0, 0);
        end

        // R4/R6: 41-row frames with writes into horizontal and vertical regions
        tag = "R4";
        for (int t = 0; t < 130; t++) begin
            int unsigned r = nxt_rand();
            cyc(1, 1, 1, int'(r % 656), int'((r >> 16) & 8'hFF));
            cyc(0, 1, 1, 640 + int'((r >> 8) % 16), int'((r >> 24) & 8'hFF));
        end

        // R11: tick every cycle, writes aimed at the page about to be read
        tag = "R11";
        for (int t = 0; t < 200; t++) begin
            int unsigned r = nxt_rand();
            int nr = (m_row + 1) % 41;
            int pa = (nr == 40) ? 640 + int'(r % 16) : (nr / 8) * 128 + int'(r % 128);
            cyc(1, 1, 1, pa, int'(r >> 24));
        end
        // writes between ticks must not disturb seg_data
        for (int t = 0; t < 40; t++) cyc(0, 1, 1, int'(nxt_rand() % 656), 8'hA5);

        // R9: drop back to 32 rows mid-frame; long frame must complete first
        tag = "R9";
        for (int t = 0; t < 120; t++) begin
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
        end

        // R7/R8: continuous ticks across several short frames
        tag = "R7";
        for (int t = 0; t < 100; t++) cyc(1, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule